// File: doc/BRIEF.md
# Sampling Converter Serial Port and Power-Mode Controller

This block is the digital device-side front end of a 12-bit sampling converter. It watches an active-low frame select and an external serial clock, both already synchronous to the local clock `clk`. It captures a 12-bit result word from a parallel bus when the frame select falls, and serialises that word on a data pin with a separate output-enable, which is the three-state control. It also drives the track/hold control of the sampling stage.

A frame is sixteen serial clock cycles long. The data pin shows four zero bits and then the result, most significant bit first. The number of serial clock falling edges counted when the frame select rises decides the outcome of the frame: a complete read, a conversion that is abandoned while the block stays powered, entry into power-down, or staying in or leaving power-down. A frame that begins in power-down is a dummy frame, and a status flag marks its data as invalid. The analog stages are out of scope. Power-up delay is represented by the mode flag alone.

The controller is a four-state machine. IDLE means powered and waiting. SLEEP means powered down and waiting. SHIFT means a frame is active and the pin is driven. TAIL means sixteen edges have been counted and the block waits for the release. The transitions are: IDLE or SLEEP to SHIFT on a select fall; SHIFT to TAIL on the sixteenth clock fall; SHIFT or TAIL to IDLE or SLEEP on a select rise, where the choice follows the release rule.

Top module: `sar_port_ctrl`

## Requirements
- R1: One `clk` cycle after the frame select is seen falling in IDLE or SLEEP, `sdo_oe` is 1, `sdo` is 0 (the first zero bit) and `hold` is 1, and the value on `sample` is captured.
- R2: After the k-th serial clock falling edge of a frame, for k from 1 to 15, `sdo` carries bit 15-k of the 16-bit word formed by four zeros followed by the captured sample (zeros in bits 15..12, sample bit 11 in bit 11).
- R3: On the 16th serial clock falling edge, `sdo_oe` goes to 0. Further serial clock edges leave it at 0 until the frame select rises.
- R4: In a frame that starts powered, `hold` stays 1 until the first serial clock rising edge that follows the 13th falling edge, and then goes to 0.
- R5: A rise of the frame select forces `sdo_oe` and `hold` to 0 and clears the edge count, so that the next frame starts again from its first zero bit.
- R6: In the powered mode, a release with fewer than 2 falling edges counted keeps `pd_mode` at 0.
- R7: In the powered mode, a release with 2 to 9 falling edges counted sets `pd_mode` to 1.
- R8: In the powered mode, a release with 10 or more falling edges counted keeps `pd_mode` at 0.
- R9: In power-down, a release with 10 or more falling edges counted clears `pd_mode`. A release with fewer than 10 keeps it at 1.
- R10: In a frame that starts in power-down, `hold` goes to 0 on the first serial clock edge, rising or falling, after the select fall.
- R11: `frame_valid` is set at each frame start to 1 if the frame starts powered and to 0 if it starts in power-down. It stays constant until the next frame start.
- R12: After reset, `sdo_oe`, `sdo`, `hold`, `pd_mode` and `frame_valid` are all 0.
- R13: `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock from the host |
| sample | input | 12 | Result word presented by the conversion core |
| sdo | output | 1 | Serial data bit |
| sdo_oe | output | 1 | Data pin drive enable (0 = high impedance) |
| hold | output | 1 | Track/hold control (1 = hold) |
| pd_mode | output | 1 | 1 while the block is powered down |
| frame_valid | output | 1 | 1 if the current or last frame carries a valid result |

## Verification
The hardest situation to reach is the wake-up path, where the track/hold must return early and the dummy frame must be flagged. It needs the block first sent into power-down by a release in the 2 to 9 edge window, and then a further frame that runs past the tenth edge. The stimulus chains releases at edge counts 1, 2, 5, 9, 10 and 12 and full frames in both modes, so each window boundary is crossed from each mode. A behavioural reference model built on a bit queue tracks every output on every clock. Directed checks capture the serial word and the mode after each release.

// File: rtl/sar_port_pkg.sv
package sar_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SLEEP = 2'd1,
        ST_SHIFT = 2'd2,
        ST_TAIL  = 2'd3
    } port_state_t;
endpackage

// File: rtl/sar_edge_det.sv
module sar_edge_det #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fell,
    output logic rose
);
    logic din_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= RST_VAL;
        else        din_q <= din;
    end

    assign fell = din_q & ~din;
    assign rose = ~din_q & din;
endmodule

// File: rtl/sar_edge_cnt.sv
module sar_edge_cnt #(
    parameter int LIMIT = 16,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = CW'(LIMIT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   count <= '0;
        else if (clr)                 count <= '0;
        else if (inc && count != TOP) count <= count + 1'b1;
    end
endmodule

// File: rtl/sar_shift_out.sv
module sar_shift_out #(
    parameter int RES_W  = 12,
    parameter int LEAD_Z = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [RES_W-1:0] sample,
    output logic             msb
);
    localparam int FW = RES_W + LEAD_Z;
    logic [FW-1:0] word;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     word <= '0;
        else if (load)  word <= {{LEAD_Z{1'b0}}, sample};
        else if (shift) word <= {word[FW-2:0], 1'b0};
    end

    assign msb = word[FW-1];
endmodule

// File: rtl/sar_port_ctrl.sv
module sar_port_ctrl
    import sar_port_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int LEAD_Z      = 4,
    parameter int PD_ENTER    = 2,
    parameter int PD_EXIT     = 10,
    parameter int TRACK_AFTER = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic [RES_W-1:0] sample,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             hold,
    output logic             pd_mode,
    output logic             frame_valid
);
    localparam int FRAME_LEN = RES_W + LEAD_Z;
    localparam int CW        = $clog2(FRAME_LEN + 1);
    localparam logic [CW-1:0] ENTER_C = CW'(PD_ENTER);
    localparam logic [CW-1:0] EXIT_C  = CW'(PD_EXIT);
    localparam logic [CW-1:0] TRACK_C = CW'(TRACK_AFTER);
    localparam logic [CW-1:0] LAST_C  = CW'(FRAME_LEN - 1);

    port_state_t    state, state_nx;
    logic           pd_q, pd_nx;
    logic           hold_q, fv_q, wake_q;
    logic           cs_fell, cs_rose, sc_fell, sc_rose;
    logic [CW-1:0]  cnt;
    logic           in_frame, start, shift_en, last_edge, word_msb;

    sar_edge_det #(.RST_VAL(1'b1)) u_cs_edge (
        .clk(clk), .rst_n(rst_n), .din(cs_n), .fell(cs_fell), .rose(cs_rose)
    );

    sar_edge_det #(.RST_VAL(1'b1)) u_sclk_edge (
        .clk(clk), .rst_n(rst_n), .din(sclk), .fell(sc_fell), .rose(sc_rose)
    );

    assign in_frame  = (state == ST_SHIFT) || (state == ST_TAIL);
    assign start     = cs_fell && !in_frame;
    assign shift_en  = (state == ST_SHIFT) && sc_fell && !cs_rose;
    assign last_edge = shift_en && (cnt == LAST_C);

    sar_edge_cnt #(.LIMIT(FRAME_LEN), .CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .clr(start || cs_rose), .inc(shift_en), .count(cnt)
    );

    sar_shift_out #(.RES_W(RES_W), .LEAD_Z(LEAD_Z)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(start), .shift(shift_en),
        .sample(sample), .msb(word_msb)
    );

    // Mode chosen by the release point (edge count when the select rises)
    function automatic logic mode_after_release(input logic pd, input logic [CW-1:0] c);
        if (pd) return (c < EXIT_C);
        return (c >= ENTER_C) && (c < EXIT_C);
    endfunction

    always_comb begin
        state_nx = state;
        pd_nx    = pd_q;
        unique case (state)
            ST_IDLE:  if (cs_fell) state_nx = ST_SHIFT;
            ST_SLEEP: if (cs_fell) state_nx = ST_SHIFT;
            ST_SHIFT, ST_TAIL: begin
                if (cs_rose) begin
                    pd_nx    = mode_after_release(pd_q, cnt);
                    state_nx = pd_nx ? ST_SLEEP : ST_IDLE;
                end else if (last_edge) begin
                    state_nx = ST_TAIL;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            pd_q  <= 1'b0;
        end else begin
            state <= state_nx;
            pd_q  <= pd_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
            fv_q   <= 1'b0;
            wake_q <= 1'b0;
        end else if (start) begin
            hold_q <= 1'b1;
            fv_q   <= ~pd_q;
            wake_q <= pd_q;
        end else if (cs_rose) begin
            hold_q <= 1'b0;
        end else if (in_frame && hold_q) begin
            if (wake_q && (sc_fell || sc_rose))
                hold_q <= 1'b0;
            else if (!wake_q && sc_rose && cnt >= TRACK_C)
                hold_q <= 1'b0;
        end
    end

    always_comb begin
        sdo_oe = 1'b0;
        sdo    = 1'b0;
        unique case (state)
            ST_SHIFT: begin
                sdo_oe = 1'b1;
                sdo    = word_msb;
            end
            ST_IDLE, ST_SLEEP, ST_TAIL: begin
                sdo_oe = 1'b0;
                sdo    = 1'b0;
            end
        endcase
    end

    assign hold        = hold_q;
    assign pd_mode     = pd_q;
    assign frame_valid = fv_q;
endmodule

// File: rtl/sar_port_chk.sv
module sar_port_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sdo,
    input logic sdo_oe,
    input logic hold,
    input logic pd_mode,
    input logic frame_valid
);
    assert_first_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cs_n) && !cs_n) |=> (sdo_oe && !sdo && hold))
        else $error("R1 frame start outputs wrong");

    assert_release_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> (!sdo_oe && !hold))
        else $error("R5 bus or hold active while deselected");

    assert_mode_at_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pd_mode) |-> ($past(cs_n) && !$past(cs_n, 2)))
        else $error("R7 mode changed away from a release");

    assert_status_steady_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sdo_oe && $past(sdo_oe)) |-> $stable(frame_valid))
        else $error("R11 status changed inside a frame");
endmodule

bind sar_port_ctrl sar_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .sdo_oe(sdo_oe),
    .hold(hold), .pd_mode(pd_mode), .frame_valid(frame_valid)
);

// File: tb/sar_port_ctrl_bench.sv
module sar_port_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b1;
    logic [11:0] sample = '0;
    logic        sdo, sdo_oe, hold, pd_mode, frame_valid;

    int  n_checks = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    // captured per frame
    logic [15:0] got_word;
    logic        start_oe, start_sdo, start_hold;
    logic        oe_after_fall [0:31];
    logic        hold_after_fall [0:31];
    logic        hold_after_rise [0:31];
    logic        end_oe, end_hold, end_sdo;

    // reference model state
    bit       m_csq = 1'b1, m_sclkq = 1'b1;
    bit       m_inframe = 1'b0, m_active = 1'b0;
    int       m_cnt = 0;
    bit       m_pd = 1'b0, m_hold = 1'b0, m_fv = 1'b0, m_wake = 1'b0;
    bit       m_bits [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sar_port_ctrl u_sar_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sample(sample),
        .sdo(sdo), .sdo_oe(sdo_oe), .hold(hold), .pd_mode(pd_mode),
        .frame_valid(frame_valid)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check16(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: updated on each rising clock edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_csq = 1'b1; m_sclkq = 1'b1; m_inframe = 1'b0; m_active = 1'b0;
            m_cnt = 0; m_pd = 1'b0; m_hold = 1'b0; m_fv = 1'b0; m_wake = 1'b0;
            m_bits.delete();
        end else begin
            bit csf, csr, sf, sr;
            csf = m_csq && !cs_n;
            csr = !m_csq && cs_n;
            sf  = m_sclkq && !sclk;
            sr  = !m_sclkq && sclk;
            if (csr) begin
                if (m_inframe) begin
                    if (m_pd) m_pd = (m_cnt < 10);
                    else      m_pd = (m_cnt >= 2 && m_cnt < 10);
                end
                m_inframe = 1'b0; m_active = 1'b0; m_hold = 1'b0; m_cnt = 0;
            end else if (csf && !m_inframe) begin
                m_inframe = 1'b1; m_active = 1'b1; m_cnt = 0; m_hold = 1'b1;
                m_fv = !m_pd; m_wake = m_pd;
                m_bits.delete();
                for (int i = 0; i < 4; i++) m_bits.push_back(1'b0);
                for (int i = 11; i >= 0; i--) m_bits.push_back(sample[i]);
            end else if (m_inframe) begin
                int c0;
                c0 = m_cnt;
                if (m_active && sf) begin
                    m_cnt++;
                    void'(m_bits.pop_front());
                    if (m_cnt == 16) m_active = 1'b0;
                end
                if (m_hold && m_wake && (sf || sr)) m_hold = 1'b0;
                else if (m_hold && !m_wake && sr && c0 >= 13) m_hold = 1'b0;
            end
            m_csq = cs_n;
            m_sclkq = sclk;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit e_sdo;
            e_sdo = (m_active && m_bits.size() > 0) ? m_bits[0] : 1'b0;
            n_checks++;
            if (sdo_oe !== m_active || sdo !== e_sdo || hold !== m_hold ||
                pd_mode !== m_pd || frame_valid !== m_fv) begin
                n_bad++;
                if (sdo !== e_sdo)         $display("FAIL R2 model sdo actual=%0b expected=%0b at %0t", sdo, e_sdo, $time);
                if (sdo_oe !== m_active)   $display("FAIL R3 model oe actual=%0b expected=%0b at %0t", sdo_oe, m_active, $time);
                if (hold !== m_hold)       $display("FAIL R4 model hold actual=%0b expected=%0b at %0t", hold, m_hold, $time);
                if (pd_mode !== m_pd)      $display("FAIL R7 model mode actual=%0b expected=%0b at %0t", pd_mode, m_pd, $time);
                if (frame_valid !== m_fv)  $display("FAIL R11 model status actual=%0b expected=%0b at %0t", frame_valid, m_fv, $time);
            end
        end
    end

    // One frame: select falls, n serial clock cycles, select rises
    task automatic run_frame(input logic [11:0] val, input int n_edges);
        sample = val;
        @(negedge clk); cs_n = 1'b0;
        @(negedge clk); @(negedge clk);
        start_oe = sdo_oe; start_sdo = sdo; start_hold = hold;
        got_word = '0;
        got_word[15] = sdo;
        for (int k = 1; k <= n_edges; k++) begin
            sclk = 1'b0;
            @(negedge clk); @(negedge clk);
            oe_after_fall[k] = sdo_oe;
            hold_after_fall[k] = hold;
            if (k <= 15) got_word[15-k] = sdo;
            sclk = 1'b1;
            @(negedge clk); @(negedge clk);
            hold_after_rise[k] = hold;
        end
        cs_n = 1'b1;
        @(negedge clk); @(negedge clk);
        end_oe = sdo_oe; end_hold = hold; end_sdo = sdo;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 oe", sdo_oe, 1'b0);
        check("R12 sdo", sdo, 1'b0);
        check("R12 hold", hold, 1'b0);
        check("R12 mode", pd_mode, 1'b0);
        check("R12 status", frame_valid, 1'b0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Full frame, powered, with two extra clocks after the sixteenth
        run_frame(12'hA5C, 18);
        check("R1 oe", start_oe, 1'b1);
        check("R1 sdo", start_sdo, 1'b0);
        check("R1 hold", start_hold, 1'b1);
        check16("R2 word A5C", got_word, 16'h0A5C);
        check("R3 oe before last", oe_after_fall[15], 1'b1);
        check("R3 oe at 16", oe_after_fall[16], 1'b0);
        check("R3 oe extra", oe_after_fall[18], 1'b0);
        check("R4 hold after rise 12", hold_after_rise[12], 1'b1);
        check("R4 hold after fall 13", hold_after_fall[13], 1'b1);
        check("R4 hold after rise 13", hold_after_rise[13], 1'b0);
        check("R8 mode full frame", pd_mode, 1'b0);
        check("R11 status powered", frame_valid, 1'b1);
        check("R13 idle sdo", end_sdo, 1'b0);

        run_frame(12'hFFF, 16);
        check16("R2 word FFF", got_word, 16'h0FFF);
        run_frame(12'h001, 16);
        check16("R2 word 001", got_word, 16'h0001);

        // Release after 1 edge: stays powered
        run_frame(12'h3C3, 1);
        check("R6 mode", pd_mode, 1'b0);
        check("R5 oe at release", end_oe, 1'b0);
        check("R5 hold at release", end_hold, 1'b0);

        // Release after 12 edges: stays powered, next frame starts clean
        run_frame(12'h777, 12);
        check("R8 mode at 12", pd_mode, 1'b0);
        run_frame(12'h924, 16);
        check16("R5 clean restart word", got_word, 16'h0924);

        // Release at exactly 2: power-down
        run_frame(12'h111, 2);
        check("R7 mode at 2", pd_mode, 1'b1);

        // In power-down, release at 5: stays down, dummy frame, early track
        run_frame(12'h555, 5);
        check("R11 status dummy", frame_valid, 1'b0);
        check("R10 hold after first fall", hold_after_fall[1], 1'b0);
        check("R10 hold at start", start_hold, 1'b1);
        check("R9 mode stays down", pd_mode, 1'b1);

        // In power-down, release at exactly 10: wakes
        run_frame(12'h666, 10);
        check("R9 mode wakes at 10", pd_mode, 1'b0);
        check("R11 status wake frame", frame_valid, 1'b0);
        run_frame(12'hB3D, 16);
        check("R11 status after wake", frame_valid, 1'b1);
        check16("R2 word after wake", got_word, 16'h0B3D);

        // Release at 9: power-down; then full frame wakes
        run_frame(12'h222, 9);
        check("R7 mode at 9", pd_mode, 1'b1);
        run_frame(12'h0F0, 16);
        check("R9 mode wakes full", pd_mode, 1'b0);
        check("R10 hold early in full wake", hold_after_fall[1], 1'b0);

        // Release at exactly 10 while powered
        run_frame(12'h8E1, 10);
        check("R8 mode at 10", pd_mode, 1'b0);
        check("R13 quiet bus", sdo, 1'b0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end
endmodule